// File: doc/BRIEF.md
# Buffered I2C Master Byte Engine

This block moves single bytes over the two I2C wires on behalf of software. Software sees one 8-bit data register, two self-clearing command bits (one to send, one to receive) and one acknowledge bit. On a send, the acknowledge bit reports what the slave answered. On a receive, it holds the answer the master will give. Behind the data register sits a shift register. It drives or samples the data line while a divider-based clock generator produces SCL.

Each command bit works as a one-deep queue. Once the engine has taken a byte (a send byte copied into the shift register, or a receive past its second bit), software may post the next command while the current byte is still on the wire. The next byte then follows the ninth clock with no gap. A pulse marks the moment the send buffer is free, and another marks a freshly received byte. Bus conditions such as START, STOP, addressing, clock stretching and arbitration belong to the surrounding logic and are not generated here.

Top module: `i2c_byte_master`

## Requirements
- R1: While reset is asserted and right after it, scl_o and sda_o are 1 (released), tx_go, rx_go, rx_ready, ack_bit and both event outputs are 0, and rd_byte is 0x00.
- R2: A command write with cmd_tx=1 and cmd_rx=0 sets tx_go. One with cmd_rx=1 and cmd_tx=0 sets rx_go. One with both set to 1 changes neither bit and starts no transfer.
- R3: A byte occupies 9 bit cells of 2*HALF clocks each. In each cell scl_o is 0 for the first HALF clocks and 1 for the last HALF. The first cell begins the cycle after the engine takes a pending command. sda_o changes only in cycles where scl_o is 0.
- R4: On a send, data bits go out MSB first with a 1 bit as sda_o=1 and a 0 bit as sda_o=0, and sda_o is 1 (released) throughout the ninth cell.
- R5: When a send byte is copied into the shift register, tx_go reads 0 and tx_empty_evt is 1 for exactly that one cycle.
- R6: After a send, ack_bit takes the value of sda_i sampled in the last clock of the ninth cell: 0 means ACK and 1 means NAK.
- R7: On a receive, sda_o stays 1 in cells 1 to 8 and sda_i is sampled in the last clock of each cell, MSB first, where a high line reads as 1.
- R8: On a receive, ack_bit as held at the end of the eighth cell is driven on sda_o for all of the ninth cell (0 = ACK, 1 = NAK).
- R9: When a receive byte completes, rd_byte shows it, rx_ready becomes 1 and rx_full_evt pulses for one cycle. A data_re pulse clears rx_ready. A further byte that completes unread replaces rd_byte silently.
- R10: rx_go clears at the end of the second cell of a receive (after bit 6 is sampled). An rx command given before that point adds no extra byte.
- R11: A command pending at the end of the ninth cell starts the next byte in the very next cycle with no idle gap. When both are pending, the send goes first.
- R12: Between bytes, once at least one byte has finished, scl_o is held at 0 and sda_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 8 | Byte written to the data register |
| ack_we | input | 1 | Write strobe for the acknowledge bit |
| ack_wdata | input | 1 | Value written to the acknowledge bit |
| cmd_we | input | 1 | Write strobe for the command bits |
| cmd_tx | input | 1 | Send request in a command write |
| cmd_rx | input | 1 | Receive request in a command write |
| data_re | input | 1 | Read strobe of the data register (clears rx_ready) |
| rd_byte | output | 8 | Current data register contents |
| ack_bit | output | 1 | Acknowledge bit (status after a send, value to give on a receive) |
| tx_go | output | 1 | Pending send command |
| rx_go | output | 1 | Pending receive command |
| rx_ready | output | 1 | Unread received byte present |
| tx_empty_evt | output | 1 | One-cycle pulse: send byte taken into the shift register |
| rx_full_evt | output | 1 | One-cycle pulse: received byte placed in the data register |
| scl_o | output | 1 | Serial clock level |
| sda_o | output | 1 | Data line drive: 0 pulls low, 1 releases |
| sda_i | input | 1 | Data line level as seen on the bus |

## Verification
The send path is driven with 0xA5, 0x3C, 0xC3, 0xFF and 0x00, so that alternating, nibble-split, all-ones and all-zeros patterns expose bit-order, inversion and stuck-bit faults. Slaves answer ACK and NAK to tell a captured acknowledge apart from a stale one. The receive path takes 0x96, 0x5A and 0x0F with ACK and NAK replies, and includes an unread overwrite. Rx commands are placed before and after the bit-6 point to separate an absorbed command from a queued one. Back-to-back sends and a send/receive collision check that the queue closes the gap and honours the ordering. A reference model driven in integer time predicts every output on every cycle.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  parameter int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // bit that goes on the wire next when sending (MSB leads)
  function automatic logic lead_bit(input byte_t b);
    return b[BYTE_W-1];
  endfunction

  // receive: append the sampled line level at the LSB end
  function automatic byte_t push_bit(input byte_t b, input logic bit_in);
    return {b[BYTE_W-2:0], bit_in};
  endfunction

  // send: drop the bit just sent
  function automatic byte_t drop_bit(input byte_t b);
    return {b[BYTE_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/i2cb_bit_timer.sv
module i2cb_bit_timer #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cell_last,
  output logic scl_hi
);
  localparam int unsigned CELL = 2 * HALF;
  localparam int unsigned PW   = (CELL > 1) ? $clog2(CELL) : 1;
  localparam logic [PW-1:0] PH_END = PW'(CELL - 1);
  localparam logic [PW-1:0] PH_HI  = PW'(HALF);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ph_q <= '0;
    end else if (ph_q == PH_END) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign cell_last = run && (ph_q == PH_END);
  assign scl_hi    = (ph_q >= PH_HI);

  // R3
  cell_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_last |=> (!scl_hi));
endmodule

// File: rtl/i2cb_byte_seq.sv
module i2cb_byte_seq
  import i2cb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_go,
  input  logic  rx_go,
  input  byte_t data_q,
  input  logic  ack_q,
  input  logic  sda_i,
  input  logic  cell_last,
  input  logic  scl_hi,
  output logic  busy,
  output logic  load_tx,
  output logic  rx_bit6,
  output logic  rx_done,
  output byte_t rx_byte,
  output logic  ack_cap_en,
  output logic  ack_cap_val,
  output logic  scl_o,
  output logic  sda_o
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] ACK_CELL  = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST_DATA = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] SECOND    = CW'(1);

  logic          busy_q, parked_q, ack_drv_q;
  dir_e          dir_q;
  logic [CW-1:0] cell_q;
  byte_t         sh_q;

  logic byte_end, start;

  assign byte_end = cell_last && (cell_q == ACK_CELL);
  assign start    = (!busy_q || byte_end) && (tx_go || rx_go);
  assign load_tx  = start && tx_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      parked_q  <= 1'b0;
      ack_drv_q <= 1'b1;
      dir_q     <= DIR_RX;
      cell_q    <= '0;
      sh_q      <= '0;
    end else begin
      if (byte_end) parked_q <= 1'b1;
      if (start) begin
        busy_q <= 1'b1;
        dir_q  <= tx_go ? DIR_TX : DIR_RX;
        cell_q <= '0;
        sh_q   <= tx_go ? data_q : '0;
      end else if (byte_end) begin
        busy_q <= 1'b0;
      end else if (cell_last) begin
        cell_q <= cell_q + 1'b1;
        sh_q   <= (dir_q == DIR_TX) ? drop_bit(sh_q) : push_bit(sh_q, sda_i);
        if (cell_q == LAST_DATA) ack_drv_q <= ack_q;
      end
    end
  end

  assign busy        = busy_q;
  assign rx_bit6     = busy_q && (dir_q == DIR_RX) && cell_last && (cell_q == SECOND);
  assign rx_done     = byte_end && (dir_q == DIR_RX);
  assign rx_byte     = sh_q;
  assign ack_cap_en  = byte_end && (dir_q == DIR_TX);
  assign ack_cap_val = sda_i;

  always_comb begin
    if (!busy_q) begin
      scl_o = !parked_q;
      sda_o = 1'b1;
    end else begin
      scl_o = scl_hi;
      if (cell_q == ACK_CELL) sda_o = (dir_q == DIR_TX) ? 1'b1 : ack_drv_q;
      else                    sda_o = (dir_q == DIR_TX) ? lead_bit(sh_q) : 1'b1;
    end
  end

  // R3
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_o != $past(sda_o)) |-> !scl_o);

  // R11
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tx_go || rx_go));
endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
  import i2cb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  data_we,
  input  byte_t data_wdata,
  input  logic  ack_we,
  input  logic  ack_wdata,
  input  logic  cmd_we,
  input  logic  cmd_tx,
  input  logic  cmd_rx,
  input  logic  data_re,
  input  logic  load_tx,
  input  logic  rx_bit6,
  input  logic  rx_done,
  input  byte_t rx_byte,
  input  logic  ack_cap_en,
  input  logic  ack_cap_val,
  output byte_t data_q,
  output logic  ack_q,
  output logic  tx_go_q,
  output logic  rx_go_q,
  output logic  rx_ready_q,
  output logic  tx_empty_evt_q,
  output logic  rx_full_evt_q
);
  logic set_tx, set_rx;
  assign set_tx = cmd_we && cmd_tx && !cmd_rx;
  assign set_rx = cmd_we && cmd_rx && !cmd_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q         <= '0;
      ack_q          <= 1'b0;
      tx_go_q        <= 1'b0;
      rx_go_q        <= 1'b0;
      rx_ready_q     <= 1'b0;
      tx_empty_evt_q <= 1'b0;
      rx_full_evt_q  <= 1'b0;
    end else begin
      if (load_tx) tx_go_q <= 1'b0;
      if (set_tx)  tx_go_q <= 1'b1;
      if (rx_bit6) rx_go_q <= 1'b0;
      if (set_rx)  rx_go_q <= 1'b1;
      if (data_we) data_q <= data_wdata;
      if (rx_done) data_q <= rx_byte;
      if (ack_we)     ack_q <= ack_wdata;
      if (ack_cap_en) ack_q <= ack_cap_val;
      if (data_re) rx_ready_q <= 1'b0;
      if (rx_done) rx_ready_q <= 1'b1;
      tx_empty_evt_q <= load_tx;
      rx_full_evt_q  <= rx_done;
    end
  end

  // R5
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_tx && !set_tx) |=> (!tx_go_q && tx_empty_evt_q));

  // R2
  both_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_tx && cmd_rx && !load_tx && !rx_bit6)
      |=> (tx_go_q == $past(tx_go_q) && rx_go_q == $past(rx_go_q)));

  // R9
  rx_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (rx_ready_q && rx_full_evt_q && data_q == $past(rx_byte)));

  // R6
  ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cap_en |=> (ack_q == $past(ack_cap_val)));

  // R10
  rx_go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bit6 && !set_rx) |=> !rx_go_q);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int unsigned HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_we,
  input  logic [7:0]  data_wdata,
  input  logic        ack_we,
  input  logic        ack_wdata,
  input  logic        cmd_we,
  input  logic        cmd_tx,
  input  logic        cmd_rx,
  input  logic        data_re,
  output logic [7:0]  rd_byte,
  output logic        ack_bit,
  output logic        tx_go,
  output logic        rx_go,
  output logic        rx_ready,
  output logic        tx_empty_evt,
  output logic        rx_full_evt,
  output logic        scl_o,
  output logic        sda_o,
  input  logic        sda_i
);
  // internal events, named for the checkers
  logic  busy, cell_last, scl_hi;
  logic  load_tx, rx_bit6, rx_done, ack_cap_en, ack_cap_val;
  byte_t rx_byte, data_q;
  logic  ack_q;

  i2cb_bit_timer #(.HALF(HALF)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .cell_last (cell_last),
    .scl_hi    (scl_hi)
  );

  i2cb_byte_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_go       (tx_go),
    .rx_go       (rx_go),
    .data_q      (data_q),
    .ack_q       (ack_q),
    .sda_i       (sda_i),
    .cell_last   (cell_last),
    .scl_hi      (scl_hi),
    .busy        (busy),
    .load_tx     (load_tx),
    .rx_bit6     (rx_bit6),
    .rx_done     (rx_done),
    .rx_byte     (rx_byte),
    .ack_cap_en  (ack_cap_en),
    .ack_cap_val (ack_cap_val),
    .scl_o       (scl_o),
    .sda_o       (sda_o)
  );

  i2cb_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .data_we        (data_we),
    .data_wdata     (data_wdata),
    .ack_we         (ack_we),
    .ack_wdata      (ack_wdata),
    .cmd_we         (cmd_we),
    .cmd_tx         (cmd_tx),
    .cmd_rx         (cmd_rx),
    .data_re        (data_re),
    .load_tx        (load_tx),
    .rx_bit6        (rx_bit6),
    .rx_done        (rx_done),
    .rx_byte        (rx_byte),
    .ack_cap_en     (ack_cap_en),
    .ack_cap_val    (ack_cap_val),
    .data_q         (data_q),
    .ack_q          (ack_q),
    .tx_go_q        (tx_go),
    .rx_go_q        (rx_go),
    .rx_ready_q     (rx_ready),
    .tx_empty_evt_q (tx_empty_evt),
    .rx_full_evt_q  (rx_full_evt)
  );

  assign rd_byte = data_q;
  assign ack_bit = ack_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (scl_o && sda_o && !tx_go && !rx_go && !rx_ready));
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int H     = 4;
  localparam int CELLC = 2 * H;
  localparam int BYTEC = 9 * CELLC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data_we = 0, ack_we = 0, ack_wdata = 0, cmd_we = 0, cmd_tx = 0, cmd_rx = 0, data_re = 0;
  logic [7:0] data_wdata = 8'h00;
  logic [7:0] rd_byte;
  logic       ack_bit, tx_go, rx_go, rx_ready, tx_empty_evt, rx_full_evt, scl_o, sda_o, sda_line;

  always #2.5 clk = ~clk;

  // bench slave and reference model state
  logic [7:0] slave_byte = 8'h00;
  logic       slave_nak = 1'b0;
  logic       slave_bit;
  int         m_t;
  logic       m_busy, m_tx, m_parked, m_tx_go, m_rx_go, m_ready, m_tev, m_rev, m_ack, m_acksend;
  logic [7:0] m_data, m_byte;
  int         n_cmp = 0, n_bad = 0, n_rxev = 0, cyc = 0;
  bit         done = 0;

  i2c_byte_master #(.HALF(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
    .ack_we(ack_we), .ack_wdata(ack_wdata), .cmd_we(cmd_we), .cmd_tx(cmd_tx),
    .cmd_rx(cmd_rx), .data_re(data_re), .rd_byte(rd_byte), .ack_bit(ack_bit),
    .tx_go(tx_go), .rx_go(rx_go), .rx_ready(rx_ready), .tx_empty_evt(tx_empty_evt),
    .rx_full_evt(rx_full_evt), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line)
  );

  // slave drives from the model's notion of the current cell
  always_comb begin
    int c;
    c = m_t / CELLC;
    if (!m_busy)    slave_bit = 1'b1;
    else if (c < 8) slave_bit = m_tx ? 1'b1 : m_byte[7-c];
    else            slave_bit = m_tx ? slave_nak : 1'b1;
  end
  assign sda_line = sda_o & slave_bit;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model, integer timeline inside a byte
  bit last_b, st_b, ntg, nrg;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_t <= 0; m_busy <= 0; m_tx <= 0; m_parked <= 0; m_tx_go <= 0; m_rx_go <= 0;
      m_ready <= 0; m_tev <= 0; m_rev <= 0; m_ack <= 0; m_acksend <= 1; m_data <= 0; m_byte <= 0;
    end else begin
      last_b = m_busy && (m_t == BYTEC - 1);
      st_b   = (!m_busy || last_b) && (m_tx_go || m_rx_go);
      ntg = m_tx_go; nrg = m_rx_go;
      m_tev <= 0; m_rev <= 0;
      if (st_b) begin
        m_busy <= 1; m_t <= 0; m_tx <= m_tx_go;
        if (m_tx_go) begin m_byte <= m_data; ntg = 0; m_tev <= 1; end
        else m_byte <= slave_byte;
      end else if (last_b) begin
        m_busy <= 0;
      end else if (m_busy) begin
        m_t <= m_t + 1;
      end
      if (last_b) m_parked <= 1;
      if (m_busy && !m_tx && m_t == 2 * CELLC - 1) nrg = 0;
      if (m_busy && !m_tx && m_t == 8 * CELLC - 1) m_acksend <= m_ack;
      if (cmd_we && cmd_tx && !cmd_rx) ntg = 1;
      if (cmd_we && cmd_rx && !cmd_tx) nrg = 1;
      m_tx_go <= ntg; m_rx_go <= nrg;
      if (ack_we) m_ack <= ack_wdata;
      if (data_we) m_data <= data_wdata;
      if (data_re) m_ready <= 0;
      if (last_b && m_tx) m_ack <= slave_nak;
      if (last_b && !m_tx) begin m_data <= m_byte; m_ready <= 1; m_rev <= 1; end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int c, p;
    logic es, ed;
    string st;
    if (rst_n) begin
      c = m_t / CELLC; p = m_t % CELLC;
      if (!m_busy) begin es = !m_parked; ed = 1; st = "R12"; end
      else begin
        es = (p >= H);
        if (c < 8) begin ed = m_tx ? m_byte[7-c] : 1'b1; st = m_tx ? "R4" : "R7"; end
        else       begin ed = m_tx ? 1'b1 : m_acksend;  st = m_tx ? "R4" : "R8"; end
      end
      chk(m_busy ? "R3" : "R12", "scl_o", scl_o, es);
      chk(st, "sda_o", sda_o, ed);
      chk("R5", "tx_go", tx_go, m_tx_go);
      chk("R10", "rx_go", rx_go, m_rx_go);
      chk("R5", "tx_empty_evt", tx_empty_evt, m_tev);
      chk("R9", "rx_full_evt", rx_full_evt, m_rev);
      chk("R9", "rx_ready", rx_ready, m_ready);
      chk("R9", "rd_byte", rd_byte, m_data);
      chk("R6", "ack_bit", ack_bit, m_ack);
      if (rx_full_evt) n_rxev++;
    end
  end

  task automatic wr_data(input logic [7:0] b);
    @(negedge clk); data_we = 1; data_wdata = b;
    @(negedge clk); data_we = 0;
  endtask
  task automatic wr_ack(input logic v);
    @(negedge clk); ack_we = 1; ack_wdata = v;
    @(negedge clk); ack_we = 0;
  endtask
  task automatic cmd(input logic t, input logic r);
    @(negedge clk); cmd_we = 1; cmd_tx = t; cmd_rx = r;
    @(negedge clk); cmd_we = 0; cmd_tx = 0; cmd_rx = 0;
  endtask
  task automatic rd();
    @(negedge clk); data_re = 1;
    @(negedge clk); data_re = 0;
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (m_busy || m_tx_go || m_rx_go);
    @(negedge clk);
  endtask
  task automatic wait_tev();
    do @(negedge clk); while (!tx_empty_evt);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int c1, c2, ev0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "scl_o reset", scl_o, 1);
    chk("R1", "sda_o reset", sda_o, 1);
    chk("R1", "go bits reset", {tx_go, rx_go}, 0);
    chk("R1", "ready/ack reset", {rx_ready, ack_bit}, 0);
    chk("R1", "events reset", {tx_empty_evt, rx_full_evt}, 0);
    chk("R1", "rd_byte reset", rd_byte, 0);
    @(negedge clk); rst_n = 1;

    // single send with ACK
    slave_nak = 0;
    wr_data(8'hA5);
    cmd(1, 0);
    chk("R2", "tx_go after tx command", tx_go, 1);
    wait_idle();
    chk("R6", "ACK after 0xA5", ack_bit, 0);
    chk("R12", "parked scl/sda", {scl_o, sda_o}, 2'b01);

    // back-to-back sends with NAK
    slave_nak = 1;
    wr_data(8'h3C);
    cmd(1, 0);
    wait_tev(); c1 = cyc;
    wr_data(8'hC3);
    cmd(1, 0);
    wait_tev(); c2 = cyc;
    chk("R11", "gap between queued sends", c2 - c1, BYTEC);
    wait_idle();
    chk("R6", "NAK after 0xC3", ack_bit, 1);

    // both command bits at once
    cmd(1, 1);
    chk("R2", "both bits ignored", {tx_go, rx_go}, 0);
    repeat (3 * CELLC) @(negedge clk);
    chk("R2", "no transfer after both bits", {scl_o, sda_o}, 2'b01);

    // receive with ACK, then read
    wr_ack(0);
    slave_byte = 8'h96;
    cmd(0, 1);
    chk("R2", "rx_go after rx command", rx_go, 1);
    do @(negedge clk); while (!rx_full_evt);
    chk("R9", "received 0x96", rd_byte, 8'h96);
    chk("R9", "rx_ready on arrival", rx_ready, 1);
    rd();
    chk("R9", "rx_ready cleared by read", rx_ready, 0);
    wait_idle();

    // rx command before bit 6 is absorbed
    ev0 = n_rxev;
    slave_byte = 8'h69;
    cmd(0, 1);
    cmd(0, 1);
    wait_idle();
    chk("R10", "single byte for early rx command", n_rxev - ev0, 1);

    // queued receive with NAK, unread overwrite
    wr_ack(1);
    slave_byte = 8'h5A;
    cmd(0, 1);
    repeat (3 * CELLC) @(negedge clk);
    slave_byte = 8'h0F;
    cmd(0, 1);
    wait_idle();
    chk("R9", "overwrite keeps newest", rd_byte, 8'h0F);
    chk("R9", "rx_ready still set", rx_ready, 1);

    // both kinds pending: send wins
    slave_nak = 0;
    wr_data(8'hFF);
    cmd(1, 0);
    wait_tev();
    cmd(0, 1);
    wr_data(8'h00);
    cmd(1, 0);
    wait_tev();
    chk("R11", "send before queued receive", rx_go, 1);
    wait_idle();
    chk("R12", "parked after mixed run", {scl_o, sda_o}, 2'b01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule